// File: doc/BRIEF.md
# Inhibited-Fetch Line Buffer

This block sits on the path between a processor's read request port and the external bus. It serves only reads whose memory attributes forbid caching. It sees each such read as a one-cycle request that it accepts only while `req_ready` is high. By default it turns the read into a single bus transfer and returns the bus word to the requester. When the `fill_en` control bit is set, an instruction fetch with a transfer type of zero takes a different path. The block then fetches the whole 16-byte line around the address as a 4-beat burst and keeps it in a one-line buffer.

Later qualifying fetches that fall inside the buffered line are answered from the buffer one cycle after the request, with no bus traffic. The line stays in the buffer until another qualifying miss refills it or `inval_all` is pulsed. The block never issues push or invalidate operations towards cached entries. Cacheable traffic, cache arrays and tag lookup are handled elsewhere.

Top module: `cifb_top`

## Requirements
- R1: After reset `req_ready` is 1, `bus_req` and `rsp_valid` are 0, and the buffer holds no valid line, so the first qualifying read goes to the bus.
- R2: A read that does not qualify makes exactly one bus transfer with `bus_burst`=0 and `bus_addr` equal to the request address. A read qualifies when `fill_en`=1, `req_is_insn`=1 and `req_ttype`=0.
- R3: A qualifying read that misses makes a 4-beat burst with `bus_burst`=1. Beat i uses address {addr[31:4], i, 2'b00}, and the beats go in increasing order from i=0.
- R4: After a burst, `rsp_valid` rises one cycle after the last `bus_ack`. `rsp_data` is then the beat selected by the request's addr[3:2].
- R5: A qualifying read whose addr[31:4] equals the valid buffered line gets `rsp_valid` in the next cycle. Its data comes from the buffer and it raises no `bus_req`.
- R6: Reads that do not qualify never hit the buffer and never change it, even when they fall in the buffered line.
- R7: A qualifying miss to another line replaces the buffered line, so the old line misses afterwards.
- R8: An `inval_all` pulse while idle empties the buffer. The next qualifying read to the former line bursts again.
- R9: An `inval_all` pulse during a burst keeps that line from becoming valid. The current read is still answered with correct bus data.
- R10: `rsp_valid` is a one-cycle pulse. `req_ready` is 0 from the cycle after a request is accepted through the response cycle, and 1 in the cycle after.
- R11: `bus_req`, `bus_addr` and `bus_burst` hold steady until the beat is acknowledged with `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill_en | input | 1 | Enables line buffering for qualifying fetches |
| inval_all | input | 1 | One-cycle strobe that empties the buffer |
| req_valid | input | 1 | Read request, sampled only while `req_ready` is 1 |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_addr | input | 32 | Byte address of the read |
| req_is_insn | input | 1 | 1 for an instruction fetch, 0 for a data read |
| req_ttype | input | 2 | Transfer type, 0 for normal accesses |
| rsp_valid | output | 1 | One-cycle pulse carrying the read result |
| rsp_data | output | 32 | Read result |
| bus_req | output | 1 | Bus transfer request for the current beat |
| bus_burst | output | 1 | 1 while a 4-beat line burst is in progress |
| bus_addr | output | 32 | Address of the current beat |
| bus_ack | input | 1 | Current beat completes, data on `bus_rdata` |
| bus_rdata | input | 32 | Bus read data |

## Verification
The bound checker watches every cycle for the following:
- idle quietness;
- how each accepted request starts, whether as a single transfer, a line-aligned burst or a local hit with no bus request;
- the bus holding steady until each acknowledge;
- the one-cycle response pulse;
- the buffer emptying after an invalidate strobe.

Other behaviour needs the directed scenarios, because it shows up only in data returned several requests later:
- that bypassed reads leave stale buffered data untouched;
- that a refill evicts the old line;
- that a strobe in the middle of a burst cancels the fill while the current read still completes.

The scenarios also confirm the beat address order and the word picked from a burst.

// File: rtl/cifb_pkg.sv
package cifb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_BURST  = 2'd2,
        ST_RESP   = 2'd3
    } cifb_state_e;

endpackage

// File: rtl/cifb_match.sv
module cifb_match #(
    parameter int TAG_W = 28,
    parameter int TT_W  = 2
) (
    input  logic             fill_en,
    input  logic             req_is_insn,
    input  logic [TT_W-1:0]  req_ttype,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             line_valid,
    output logic             qualify,
    output logic             hit
);

    // Only enabled, normal instruction fetches may use the line buffer.
    always_comb begin
        qualify = fill_en && req_is_insn && (req_ttype == '0);
        hit     = qualify && line_valid && (req_tag == line_tag);
    end

endmodule

// File: rtl/cifb_store.sv
module cifb_store #(
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BEAT_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BEAT_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] word_q [BEATS];

    // One register per line word, each with its own write enable.
    for (genvar g = 0; g < BEATS; g++) begin : g_word
        logic [DATA_W-1:0] word_d;

        always_comb begin
            word_d = word_q[g];
            if (wr_en && (wr_idx == BEAT_W'(g))) begin
                word_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else begin
                word_q[g] <= word_d;
            end
        end
    end

    assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/cifb_ctrl.sv
module cifb_ctrl
    import cifb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int OFF_W  = BEAT_W + BYTE_W,
    localparam int TAG_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              qualify,
    input  logic              hit,
    input  logic              inval_all,
    input  logic [DATA_W-1:0] buf_rd_data,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req,
    output logic              bus_burst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              wr_en,
    output logic [BEAT_W-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [TAG_W-1:0]  line_tag,
    output logic              line_valid
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        cifb_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] beat;
        logic              cancel;
        logic [TAG_W-1:0]  tag;
        logic              valid;
        logic [DATA_W-1:0] rdata;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    logic [BEAT_W-1:0] want_idx;
    assign want_idx = ctl_q.addr[OFF_W-1:BYTE_W];

    always_comb begin
        ctl_d = ctl_q;

        // An invalidate strobe empties the buffer at once and marks any
        // fill in progress as stale.
        if (inval_all) begin
            ctl_d.valid  = 1'b0;
            ctl_d.cancel = 1'b1;
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    if (hit) begin
                        ctl_d.rdata = buf_rd_data;
                        ctl_d.st    = ST_RESP;
                    end else if (qualify) begin
                        ctl_d.st     = ST_BURST;
                        ctl_d.beat   = '0;
                        ctl_d.valid  = 1'b0;
                        ctl_d.cancel = inval_all;
                        ctl_d.tag    = req_addr[ADDR_W-1:OFF_W];
                    end else begin
                        ctl_d.st = ST_SINGLE;
                    end
                end
            end
            ST_SINGLE: begin
                if (bus_ack) begin
                    ctl_d.rdata = bus_rdata;
                    ctl_d.st    = ST_RESP;
                end
            end
            ST_BURST: begin
                if (bus_ack) begin
                    if (ctl_q.beat == want_idx) begin
                        ctl_d.rdata = bus_rdata;
                    end
                    if (ctl_q.beat == LAST_BEAT) begin
                        ctl_d.valid = !ctl_d.cancel;
                        ctl_d.st    = ST_RESP;
                    end else begin
                        ctl_d.beat = ctl_q.beat + 1'b1;
                    end
                end
            end
            ST_RESP: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, beat: '0, cancel: 1'b0,
                       tag: '0, valid: 1'b0, rdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        req_ready  = (ctl_q.st == ST_IDLE);
        rsp_valid  = (ctl_q.st == ST_RESP);
        rsp_data   = ctl_q.rdata;
        bus_req    = (ctl_q.st == ST_SINGLE) || (ctl_q.st == ST_BURST);
        bus_burst  = (ctl_q.st == ST_BURST);
        bus_addr   = ctl_q.addr;
        if (ctl_q.st == ST_BURST) begin
            bus_addr = {ctl_q.tag, ctl_q.beat, {BYTE_W{1'b0}}};
        end
        wr_en      = (ctl_q.st == ST_BURST) && bus_ack;
        wr_idx     = ctl_q.beat;
        wr_data    = bus_rdata;
        line_tag   = ctl_q.tag;
        line_valid = ctl_q.valid;
    end

endmodule

// File: rtl/cifb_top.sv
module cifb_top #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    parameter int TT_W   = 2,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int OFF_W  = BEAT_W + BYTE_W,
    localparam int TAG_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic              inval_all,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_insn,
    input  logic [TT_W-1:0]   req_ttype,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req,
    output logic              bus_burst,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic              qualify_w;
    logic              hit_w;
    logic [TAG_W-1:0]  line_tag_w;
    logic              line_valid_w;
    logic              wr_en_w;
    logic [BEAT_W-1:0] wr_idx_w;
    logic [DATA_W-1:0] wr_data_w;
    logic [DATA_W-1:0] buf_rd_w;

    cifb_match #(.TAG_W(TAG_W), .TT_W(TT_W)) u_match (
        .fill_en     (fill_en),
        .req_is_insn (req_is_insn),
        .req_ttype   (req_ttype),
        .req_tag     (req_addr[ADDR_W-1:OFF_W]),
        .line_tag    (line_tag_w),
        .line_valid  (line_valid_w),
        .qualify     (qualify_w),
        .hit         (hit_w)
    );

    cifb_store #(.DATA_W(DATA_W), .BEATS(BEATS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_w),
        .wr_idx  (wr_idx_w),
        .wr_data (wr_data_w),
        .rd_idx  (req_addr[OFF_W-1:BYTE_W]),
        .rd_data (buf_rd_w)
    );

    cifb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .qualify     (qualify_w),
        .hit         (hit_w),
        .inval_all   (inval_all),
        .buf_rd_data (buf_rd_w),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .bus_req     (bus_req),
        .bus_burst   (bus_burst),
        .bus_addr    (bus_addr),
        .wr_en       (wr_en_w),
        .wr_idx      (wr_idx_w),
        .wr_data     (wr_data_w),
        .line_tag    (line_tag_w),
        .line_valid  (line_valid_w)
    );

endmodule

// File: rtl/cifb_checker.sv
module cifb_checker #(
    parameter int ADDR_W = 32,
    parameter int TT_W   = 2,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fill_en,
    input logic              inval_all,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_is_insn,
    input logic [TT_W-1:0]   req_ttype,
    input logic              rsp_valid,
    input logic              bus_req,
    input logic              bus_burst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              hit,
    input logic              line_valid
);

    logic qual_c;
    logic accept_c;
    assign qual_c   = fill_en && req_is_insn && (req_ttype == '0);
    assign accept_c = req_valid && req_ready;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_req && !rsp_valid));

    p_bypass_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_c && !qual_c) |=> (bus_req && !bus_burst));

    p_miss_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_c && qual_c && !hit) |=>
            (bus_req && bus_burst && (bus_addr[OFF_W-1:0] == '0)));

    p_hit_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_c && hit) |=> (rsp_valid && !bus_req));

    p_inval_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> !line_valid);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_burst)));

endmodule

bind cifb_top cifb_checker #(.ADDR_W(ADDR_W), .TT_W(TT_W), .OFF_W(OFF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_en     (fill_en),
    .inval_all   (inval_all),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_is_insn (req_is_insn),
    .req_ttype   (req_ttype),
    .rsp_valid   (rsp_valid),
    .bus_req     (bus_req),
    .bus_burst   (bus_burst),
    .bus_addr    (bus_addr),
    .bus_ack     (bus_ack),
    .hit         (hit_w),
    .line_valid  (line_valid_w)
);

// File: tb/tb_cifb_top.sv
`timescale 1ns/1ps
module tb_cifb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_en = 1'b0;
    logic        inval_all = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_is_insn = 1'b0;
    logic [1:0]  req_ttype = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        bus_req;
    logic        bus_burst;
    logic [31:0] bus_addr;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    cifb_top dut (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .inval_all(inval_all),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_is_insn(req_is_insn), .req_ttype(req_ttype),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_burst(bus_burst), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Bus model state
    int          salt = 0;
    int          nbeats = 0;
    int          last_ack_cyc = 0;
    logic        last_burst = 1'b0;
    logic [31:0] addr_log [0:255];
    int          hold_bad = 0;

    function automatic logic [31:0] memval(input logic [31:0] a, input int s);
        return ((a & 32'hFFFF_FFFC) ^ 32'h5A5A_0000) + (32'h0101_0101 * s);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bus responder: one wait cycle before each acknowledge.
    initial begin
        int          wt = 0;
        logic [31:0] seen = '0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                wt = 0;
            end else if (bus_req) begin
                if (wt > 0 && bus_addr != seen) hold_bad++;
                seen = bus_addr;
                if (wt >= 1) begin
                    bus_ack   = 1'b1;
                    bus_rdata = memval(bus_addr, salt);
                    addr_log[nbeats[7:0]] = bus_addr;
                    last_burst   = bus_burst;
                    last_ack_cyc = cyc;
                    nbeats++;
                end else begin
                    wt++;
                end
            end
        end
    end

    task automatic do_read(input logic [31:0] a, input logic insn,
                           input logic [1:0] tt, input int inval_at,
                           output logic [31:0] data, output int beats,
                           output int lat, output int ack_gap);
        int b0;
        int start;
        int n;
        int ready_bad = 0;
        while (!req_ready) @(negedge clk);
        b0 = nbeats;
        req_addr = a; req_is_insn = insn; req_ttype = tt; req_valid = 1'b1;
        start = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_valid && n < 100) begin
            if (req_ready) ready_bad++;
            if (n == inval_at) inval_all = 1'b1;
            @(negedge clk);
            inval_all = 1'b0;
            n++;
        end
        chk(rsp_valid, "R10 response arrives", {31'd0, rsp_valid}, 32'd1);
        chk(!req_ready, "R10 ready low in response cycle", {31'd0, req_ready}, 32'd0);
        chk(ready_bad == 0, "R10 ready low while busy", ready_bad, 0);
        data    = rsp_data;
        beats   = nbeats - b0;
        lat     = cyc - start;
        ack_gap = cyc - last_ack_cyc;
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R10 one-cycle pulse then ready",
            {30'd0, req_ready, rsp_valid}, 32'd2);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk(bus_req == 1'b0, "R1 bus idle after reset", {31'd0, bus_req}, 32'd0);
        chk(rsp_valid == 1'b0, "R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_single;
        logic [31:0] d; int b; int l; int g;
        fill_en = 1'b1;
        do_read(32'h1000_0106, 1'b0, 2'd0, -1, d, b, l, g);
        chk(b == 1, "R2 data read single beat", b, 1);
        chk(!last_burst, "R2 burst flag low", {31'd0, last_burst}, 32'd0);
        chk(addr_log[(nbeats - 1) & 255] == 32'h1000_0106, "R2 bus address",
            addr_log[(nbeats - 1) & 255], 32'h1000_0106);
        chk(d == memval(32'h1000_0106, salt), "R2 data", d, memval(32'h1000_0106, salt));
        chk(g == 1, "R2 response after ack", g, 1);
        fill_en = 1'b0;
        do_read(32'h1000_0200, 1'b1, 2'd0, -1, d, b, l, g);
        chk(b == 1 && !last_burst, "R2 fetch with enable off is single", b, 1);
        fill_en = 1'b1;
    endtask

    task automatic t_fill(input logic [31:0] a, input int inval_at, input string tag);
        logic [31:0] d; int b; int l; int g;
        logic [31:0] base;
        base = a & 32'hFFFF_FFF0;
        do_read(a, 1'b1, 2'd0, inval_at, d, b, l, g);
        chk(b == 4, {tag, " R3 four beats"}, b, 4);
        chk(last_burst, {tag, " R3 burst flag"}, {31'd0, last_burst}, 32'd1);
        for (int i = 0; i < 4; i++) begin
            chk(addr_log[(nbeats - 4 + i) & 255] == base + 32'(4 * i),
                {tag, " R3 beat address order"},
                addr_log[(nbeats - 4 + i) & 255], base + 32'(4 * i));
        end
        chk(d == memval(a, salt), {tag, " R4 selected word"}, d, memval(a, salt));
        chk(g == 1, {tag, " R4 response after last ack"}, g, 1);
    endtask

    task automatic t_hit(input logic [31:0] a, input int s, input string tag);
        logic [31:0] d; int b; int l; int g;
        do_read(a, 1'b1, 2'd0, -1, d, b, l, g);
        chk(b == 0, {tag, " no bus beats"}, b, 0);
        chk(l == 1, {tag, " latency one cycle"}, l, 1);
        chk(d == memval(a, s), {tag, " buffered data"}, d, memval(a, s));
    endtask

    task automatic t_miss(input logic [31:0] a, input string tag);
        logic [31:0] d; int b; int l; int g;
        do_read(a, 1'b1, 2'd0, -1, d, b, l, g);
        chk(b == 4, {tag, " line refetched"}, b, 4);
        chk(d == memval(a, salt), {tag, " data"}, d, memval(a, salt));
    endtask

    task automatic t_bypass;
        logic [31:0] d; int b; int l; int g;
        salt = 1;
        do_read(32'h2000_0034, 1'b0, 2'd0, -1, d, b, l, g);
        chk(b == 1 && d == memval(32'h2000_0034, 1), "R6 data read in line uses bus",
            d, memval(32'h2000_0034, 1));
        do_read(32'h2000_0034, 1'b1, 2'd2, -1, d, b, l, g);
        chk(b == 1 && !last_burst, "R6 nonzero type uses single transfer", b, 1);
        fill_en = 1'b0;
        do_read(32'h2000_0038, 1'b1, 2'd0, -1, d, b, l, g);
        chk(b == 1, "R6 enable off no hit", b, 1);
        fill_en = 1'b1;
        t_hit(32'h2000_0034, 0, "R6 buffer unchanged R5");
    endtask

    task automatic t_inval_idle;
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        t_miss(32'h3000_0008, "R8 after idle invalidate");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        salt = 0;
        t_fill(32'h2000_0038, -1, "fill");
        t_hit(32'h2000_0030, 0, "R5 hit word0");
        t_hit(32'h2000_003C, 0, "R5 hit word3");
        t_bypass();
        salt = 2;
        t_fill(32'h3000_0004, -1, "R7 refill");
        t_miss(32'h2000_0030, "R7 old line evicted");
        salt = 3;
        t_fill(32'h3000_0004, -1, "R8 prep");
        t_inval_idle();
        salt = 4;
        t_fill(32'h4000_0014, 3, "R9 invalidate mid-burst");
        t_miss(32'h4000_0014, "R9 cancelled line");
        t_hit(32'h4000_0018, 4, "R9 refilled line hit R5");
        chk(hold_bad == 0, "R11 bus address held while waiting", hold_bad, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule